// File: doc/BRIEF.md
# RC Oscillator Conversion Counter

This block turns the frequency of an external resistor-capacitor oscillator into a number. The oscillator's period follows a sensing element such as a thermistor or a humidity-dependent capacitor, so counting its cycles over a known window measures the sensor. The oscillator arrives as a digital pulse train on an asynchronous pin. It is synchronised, and its rising edges are counted. A second time base arrives as a one-cycle reference tick in the system clock domain.

Two counters do the work. The first is a decimal counter of several BCD digits, and it is fed by oscillator edges. The second is a binary counter fed by reference ticks. A mode bit chooses which counter is the gate. The gate counter counts down from a preset value. The other counter accumulates events until the gate reaches zero. When the oscillator side accumulates, the result can be read directly in decimal digits. Software loads the presets and starts a conversion through a nibble-wide register port, then polls a done flag or takes an interrupt and reads both counters back.

Top module: `rc_conv_counter`

## Requirements
- R1: After reset, every digit and nibble of both counters reads 0, the control register reads 0, the status register reads 0 and `irq` is low.
- R2: The register map uses the following addresses. Addresses 0 to 4 hold the decimal digits, with address 0 the least significant. Addresses 5 to 8 hold the binary counter nibbles, with address 5 the least significant; address 8 carries bits 13:12 and zeros above them. Address 9 is control: bit 0 is mode and bit 1 is interrupt enable. Address 10 reads as status: bit 0 busy, bit 1 done, bit 2 overflow. Writing address 10 with bit 0 set starts a conversion. Reads are combinational from `addr`.
- R3: The oscillator input passes through a two-stage synchroniser and only its rising edges are counted. A level held high for many cycles counts exactly once.
- R4: With mode 0, each reference tick during a conversion decrements the binary counter and each oscillator edge increments the decimal counter. The conversion ends in the cycle the binary counter reaches zero.
- R5: With mode 1, each oscillator edge during a conversion decrements the decimal counter and each reference tick increments the binary counter. The conversion ends in the cycle the decimal counter reaches zero.
- R6: An increment that takes a decimal digit past 9 sets that digit to 0 and carries into the next digit. A decrement of a digit at 0 sets it to 9 and borrows from the next digit.
- R7: If the accumulating counter wraps (decimal past 99999, or binary past 16383), the counter reads 0 and the overflow status bit is set. The bit stays set until the next start.
- R8: When a conversion ends, busy clears, done sets and both counters stop changing. A start clears done and overflow. `irq` is high exactly while done and interrupt enable are both set.
- R9: While busy, writes to counter registers and to the control register are ignored, and so is a repeated start.
- R10: A start with the gate counter already at zero ends the conversion in the next cycle without counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Asynchronous oscillator pulse train |
| ref_tick | input | 1 | One-cycle reference time-base tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 4 | Register write data |
| rd_data | output | 4 | Register read data for `addr` |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
A wrong internal state shows up in a small number of places. A mis-stepped digit or a missing carry or borrow changes the decimal readback on the first oscillator edge that crosses a 9/0 boundary. That error is visible about three clocks after the pin rises, because of the synchroniser and the edge detector. A gate that stops too early or too late appears as busy still set, or already clear, on the read right after the final tick. A counter that keeps running after done appears as a changed readback after extra stimulus. A lost lock or a lost sticky flag is visible on the next register read.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   localparam int NIB = 4;

   typedef enum logic {
      GATE_ON_REF = 1'b0,
      GATE_ON_OSC = 1'b1
   } gate_mode_e;

   localparam int CTL_MODE_BIT = 0;
   localparam int CTL_IE_BIT   = 1;
   localparam int ST_BUSY_BIT  = 0;
   localparam int ST_DONE_BIT  = 1;
   localparam int ST_OVF_BIT   = 2;
   localparam int CMD_GO_BIT   = 0;
endpackage

// File: rtl/rcc_edge_sync.sv
module rcc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rcc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise = chain_q[STAGES-1] & ~last_q;

   // R3: a detected edge never lasts two cycles
   p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/rcc_bcd_counter.sv
module rcc_bcd_counter
   import rcc_pkg::*;
#(
   parameter int DIGITS = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DIGITS-1:0]     load_en,
   input  logic [NIB-1:0]        load_val,
   input  logic                  inc,
   input  logic                  dec,
   output logic [NIB*DIGITS-1:0] value,
   output logic                  carry_out,
   output logic                  is_zero,
   output logic                  is_one
);
   localparam int W = NIB * DIGITS;

   if (DIGITS < 1) begin : g_bad_digits
      $error("rcc_bcd_counter: DIGITS must be positive");
   end

   logic [DIGITS:0] cy;
   logic [DIGITS:0] bw;
   assign cy[0] = inc;
   assign bw[0] = dec & ~inc;

   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      logic [NIB-1:0] q;
      logic [NIB-1:0] nxt;
      logic           at_top;
      logic           at_floor;

      assign at_top   = (q >= 4'd9);
      assign at_floor = (q == 4'd0);
      assign cy[i+1]  = cy[i] & at_top;
      assign bw[i+1]  = bw[i] & at_floor;

      always_comb begin
         nxt = q;
         if (cy[i])      nxt = at_top ? 4'd0 : q + 4'd1;
         else if (bw[i]) nxt = at_floor ? 4'd9 : q - 4'd1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= '0;
         else if (load_en[i]) q <= load_val;
         else                 q <= nxt;
      end

      assign value[NIB*i +: NIB] = q;
   end

   assign carry_out = cy[DIGITS];
   assign is_zero   = (value == '0);
   assign is_one    = (value == W'(1));

   // R6: with no load and no count the digits keep their value
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|load_en) && !inc && !dec) |=> $stable(value));
   // R7: a carry out of the top digit leaves the counter at zero
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_out && !(|load_en)) |=> (value == '0));
endmodule

// File: rtl/rcc_bin_counter.sv
module rcc_bin_counter
   import rcc_pkg::*;
#(
   parameter int WIDTH = 14
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [(WIDTH+NIB-1)/NIB-1:0] load_en,
   input  logic [NIB-1:0]               load_val,
   input  logic                         inc,
   input  logic                         dec,
   output logic [WIDTH-1:0]             value,
   output logic                         carry_out,
   output logic                         is_zero,
   output logic                         is_one
);
   localparam int NIBS = (WIDTH + NIB - 1) / NIB;

   if (WIDTH < 2) begin : g_bad_width
      $error("rcc_bin_counter: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] nxt;

   always_comb begin
      nxt = cnt_q;
      if (|load_en) begin
         for (int b = 0; b < WIDTH; b++) begin
            if (load_en[b / NIB]) nxt[b] = load_val[b % NIB];
         end
      end else if (inc) begin
         nxt = cnt_q + WIDTH'(1);
      end else if (dec) begin
         nxt = cnt_q - WIDTH'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   assign value     = cnt_q;
   assign carry_out = inc & (&cnt_q);
   assign is_zero   = (cnt_q == '0);
   assign is_one    = (cnt_q == WIDTH'(1));

   // R7: a wrap of the binary counter lands on zero
   p_bin_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (carry_out && !(|load_en)) |=> (value == '0));
   // R9: with no load and no count the value holds
   p_bin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|load_en) && !inc && !dec) |=> $stable(value));
endmodule

// File: rtl/rc_conv_counter.sv
module rc_conv_counter
   import rcc_pkg::*;
#(
   parameter int A_DIGITS    = 5,
   parameter int B_WIDTH     = 14,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_in,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NIB-1:0]    wdata,
   output logic [NIB-1:0]    rd_data,
   output logic              irq
);
   localparam int B_NIBS    = (B_WIDTH + NIB - 1) / NIB;
   localparam int A_BASE    = 0;
   localparam int B_BASE    = A_BASE + A_DIGITS;
   localparam int CTRL_ADDR = B_BASE + B_NIBS;
   localparam int STAT_ADDR = CTRL_ADDR + 1;
   localparam int A_W       = NIB * A_DIGITS;

   if (STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("rc_conv_counter: register map does not fit ADDR_W");
   end

   // control and status state
   gate_mode_e mode_q;
   logic       irq_en_q;
   logic       busy_q;
   logic       done_q;
   logic       ovf_q;

   // counter interfaces
   logic                osc_rise;
   logic [A_DIGITS-1:0] a_load;
   logic [B_NIBS-1:0]   b_load;
   logic [A_W-1:0]      a_val;
   logic [B_WIDTH-1:0]  b_val;
   logic                a_inc, a_dec, b_inc, b_dec;
   logic                a_carry, a_zero, a_one;
   logic                b_carry, b_zero, b_one;

   logic preset_ok;
   logic ctrl_wr;
   logic start_cmd;
   logic gate_zero, gate_one, gate_event;
   logic finish;
   logic acc_wrap;

   rcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(osc_in),
      .rise    (osc_rise)
   );

   // register decode
   assign preset_ok = wr_en & ~busy_q;
   assign ctrl_wr   = preset_ok & (addr == ADDR_W'(CTRL_ADDR));
   assign start_cmd = preset_ok & (addr == ADDR_W'(STAT_ADDR)) & wdata[CMD_GO_BIT];

   for (genvar i = 0; i < A_DIGITS; i++) begin : g_a_load
      assign a_load[i] = preset_ok & (addr == ADDR_W'(A_BASE + i));
   end
   for (genvar j = 0; j < B_NIBS; j++) begin : g_b_load
      assign b_load[j] = preset_ok & (addr == ADDR_W'(B_BASE + j));
   end

   // gate selection
   always_comb begin
      if (mode_q == GATE_ON_OSC) begin
         gate_zero  = a_zero;
         gate_one   = a_one;
         gate_event = osc_rise;
         acc_wrap   = b_carry;
      end else begin
         gate_zero  = b_zero;
         gate_one   = b_one;
         gate_event = ref_tick;
         acc_wrap   = a_carry;
      end
   end

   assign finish = busy_q & (gate_zero | (gate_event & gate_one));

   assign a_inc = busy_q & (mode_q == GATE_ON_REF) & osc_rise;
   assign a_dec = busy_q & (mode_q == GATE_ON_OSC) & osc_rise & ~a_zero;
   assign b_inc = busy_q & (mode_q == GATE_ON_OSC) & ref_tick;
   assign b_dec = busy_q & (mode_q == GATE_ON_REF) & ref_tick & ~b_zero;

   rcc_bcd_counter #(.DIGITS(A_DIGITS)) u_dec_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (a_load),
      .load_val (wdata),
      .inc      (a_inc),
      .dec      (a_dec),
      .value    (a_val),
      .carry_out(a_carry),
      .is_zero  (a_zero),
      .is_one   (a_one)
   );

   rcc_bin_counter #(.WIDTH(B_WIDTH)) u_bin_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (b_load),
      .load_val (wdata),
      .inc      (b_inc),
      .dec      (b_dec),
      .value    (b_val),
      .carry_out(b_carry),
      .is_zero  (b_zero),
      .is_one   (b_one)
   );

   // conversion sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= GATE_ON_REF;
         irq_en_q <= 1'b0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            mode_q   <= gate_mode_e'(wdata[CTL_MODE_BIT]);
            irq_en_q <= wdata[CTL_IE_BIT];
         end
         if (start_cmd) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
         end else begin
            if (finish) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
            if (busy_q && acc_wrap) ovf_q <= 1'b1;
         end
      end
   end

   // readback
   logic [NIB*B_NIBS-1:0] b_pad;
   assign b_pad = (NIB*B_NIBS)'(b_val);

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < A_DIGITS; i++) begin
         if (addr == ADDR_W'(A_BASE + i)) rd_data = a_val[NIB*i +: NIB];
      end
      for (int j = 0; j < B_NIBS; j++) begin
         if (addr == ADDR_W'(B_BASE + j)) rd_data = b_pad[NIB*j +: NIB];
      end
      if (addr == ADDR_W'(CTRL_ADDR)) begin
         rd_data[CTL_MODE_BIT] = mode_q;
         rd_data[CTL_IE_BIT]   = irq_en_q;
      end
      if (addr == ADDR_W'(STAT_ADDR)) begin
         rd_data[ST_BUSY_BIT] = busy_q;
         rd_data[ST_DONE_BIT] = done_q;
         rd_data[ST_OVF_BIT]  = ovf_q;
      end
   end

   assign irq = done_q & irq_en_q;

   // R8: a start always enters the busy state with done cleared
   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_cmd |=> (busy_q && !done_q && !ovf_q));
   // R4: done only rises once the gate counter has reached zero
   p_done_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> gate_zero);
   // R8: an idle block keeps the decimal counter frozen unless software loads it
   p_idle_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !(|a_load)) |=> $stable(a_val));
   // R7: overflow is sticky until a start
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !start_cmd) |=> ovf_q);
   // R9: control writes during a conversion leave the mode alone
   p_mode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr_en && addr == ADDR_W'(CTRL_ADDR)) |=> $stable(mode_q));
endmodule

// File: tb/rc_conv_counter_test.sv
module rc_conv_counter_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_in = 1'b0;
   logic       ref_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [3:0] wdata = '0;
   logic [3:0] rd_data;
   logic       irq;

   int total = 0;
   int bad = 0;
   bit ended = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rc_conv_counter uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc_in  (osc_in),
      .ref_tick(ref_tick),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rd_data (rd_data),
      .irq     (irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = a[3:0]; wdata = d[3:0]; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      addr = a[3:0];
      #1 d = int'(rd_data);
   endtask

   task automatic read_a(output int v);
      int d;
      v = 0;
      for (int i = 4; i >= 0; i--) begin
         rd(i, d);
         v = v * 10 + d;
      end
   endtask

   task automatic read_b(output int v);
      int d;
      v = 0;
      for (int i = 3; i >= 0; i--) begin
         rd(5 + i, d);
         v = (v << 4) | d;
      end
   endtask

   task automatic set_a(input int v);
      int p = 1;
      for (int i = 0; i < 5; i++) begin
         wr(i, (v / p) % 10);
         p = p * 10;
      end
   endtask

   task automatic set_b(input int v);
      for (int i = 0; i < 4; i++) wr(5 + i, (v >> (4 * i)) & 15);
   endtask

   task automatic start();
      wr(10, 1);
   endtask

   task automatic osc_pulses(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); osc_in = 1'b1;
         @(negedge clk);
         @(negedge clk); osc_in = 1'b0;
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
      end
   endtask

   task automatic t_reset();
      int v;
      read_a(v);   chk("R1 decimal counter", v, 0);
      read_b(v);   chk("R1 binary counter", v, 0);
      rd(9, v);    chk("R1 control", v, 0);
      rd(10, v);   chk("R1 status", v, 0);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_gate_ref();
      int v;
      wr(9, 0); set_a(0); set_b(10); start();
      rd(10, v); chk("R2 busy after start", v, 1);
      @(negedge clk); osc_in = 1'b1;
      repeat (12) @(negedge clk);
      osc_in = 1'b0;
      repeat (4) @(negedge clk);
      read_a(v); chk("R3 held level counts once", v, 1);
      osc_pulses(6);
      read_a(v); chk("R3 edges counted", v, 7);
      ticks(9);
      rd(10, v); chk("R4 still busy one tick early", v, 1);
      ticks(1);
      rd(10, v); chk("R4 done on gate zero", v, 2);
      read_b(v); chk("R4 gate counter at zero", v, 0);
      osc_pulses(3);
      read_a(v); chk("R8 counting halted", v, 7);
   endtask

   task automatic t_gate_osc();
      int v;
      wr(9, 1); set_a(4); set_b(0); start();
      ticks(6);
      read_b(v); chk("R5 ticks accumulated", v, 6);
      osc_pulses(3);
      read_a(v); chk("R5 decimal gate counts down", v, 1);
      rd(10, v); chk("R5 busy before last edge", v, 1);
      osc_pulses(1);
      rd(10, v); chk("R5 done on last edge", v, 2);
      ticks(2);
      read_b(v); chk("R5 binary halted after done", v, 6);
   endtask

   task automatic t_digits();
      int v;
      wr(9, 0); set_b(100); set_a(99); start();
      osc_pulses(1);
      read_a(v); chk("R6 carry through two digits", v, 100);
      rd(2, v);  chk("R6 hundreds digit", v, 1);
      ticks(100);
      rd(10, v); chk("R6 carry run ends", v, 2);
      wr(9, 1); set_a(100); set_b(0); start();
      osc_pulses(1);
      read_a(v); chk("R6 borrow through two digits", v, 99);
      rd(1, v);  chk("R6 tens digit after borrow", v, 9);
      osc_pulses(99);
      rd(10, v); chk("R6 borrow run ends", v, 2);
   endtask

   task automatic t_overflow();
      int v;
      wr(9, 0); set_a(99999); set_b(3); start();
      osc_pulses(1);
      read_a(v); chk("R7 decimal wraps to zero", v, 0);
      rd(10, v); chk("R7 overflow while busy", v, 5);
      ticks(3);
      rd(10, v); chk("R7 overflow sticky after done", v, 6);
      wr(9, 1); set_a(2); set_b(16383); start();
      rd(10, v); chk("R7 start clears overflow", v, 1);
      ticks(1);
      read_b(v); chk("R7 binary wraps to zero", v, 0);
      rd(10, v); chk("R7 binary overflow flagged", v, 5);
      osc_pulses(2);
      rd(10, v); chk("R7 run ends with flag", v, 6);
   endtask

   task automatic t_lock();
      int v;
      wr(9, 0); set_a(0); set_b(50); start();
      wr(0, 5);
      read_a(v); chk("R9 digit write ignored", v, 0);
      wr(9, 3);
      rd(9, v);  chk("R9 control write ignored", v, 0);
      wr(5, 1);
      read_b(v); chk("R9 nibble write ignored", v, 50);
      start();
      rd(10, v); chk("R9 repeated start ignored", v, 1);
      ticks(50);
      rd(10, v); chk("R9 run ends normally", v, 2);
   endtask

   task automatic t_zero_gate_irq();
      int v;
      wr(9, 2); set_b(0); start();
      rd(10, v); chk("R10 zero preset ends at once", v, 2);
      chk("R8 irq with enable and done", int'(irq), 1);
      set_b(5); start();
      chk("R8 start drops irq", int'(irq), 0);
      ticks(5);
      chk("R8 irq after conversion", int'(irq), 1);
      wr(9, 0);
      chk("R8 irq masked by enable", int'(irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_gate_ref();
      t_gate_osc();
      t_digits();
      t_overflow();
      t_lock();
      t_zero_gate_irq();
      if (!ended) begin
         ended = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule